// File: doc/BRIEF.md
# Split-Matrix Phase Accumulator Array

This block turns a slope vector into a phase vector by a streamed matrix-vector product. For an n by n grid of subapertures the phase vector holds (n+1)^2 entries. The matrix has 2n^2 columns and is kept as two halves. One half weights the x-slopes and the other weights the y-slopes. An upstream fetch engine streams the matrix to the block one beat at a time. Each beat carries one weight pair per lane, for a group of consecutive phase rows, together with the x-slope and y-slope of the current column. Every lane forms both products, adds them to the running phase of its row, and writes the sum back to on-chip storage.

The phase storage is split into one bank per lane. Lane l owns the rows g*LANES+l. The block therefore needs no arbitration, and a column can start as soon as its slope pair exists, without waiting for the other slopes of the same subaperture row. A clear pulse opens a frame. A one-cycle done pulse closes it. After done, the phases are read out one address at a time through a registered read port.

Top module: `split_mvm_mac`

## Requirements
- R1: After reset, every phase entry reads as zero, `done` is low and `in_ready` is high.
- R2: Beats are consumed in this order: column c ascending from 0 to n^2-1, and within each column row group g ascending from 0 to ceil((n+1)^2/LANES)-1. In a beat, lane l carries the weights for phase row g*LANES+l, in bits [16l+15:16l] of `in_wx` (x half) and `in_wy` (y half). `in_xs` and `in_ys` carry the slopes of column c.
- R3: An accepted beat updates each addressed row as phase <= sat(phase + sat((wx*xs)>>>MFRAC) + sat((wy*ys)>>>MFRAC)). Weights are signed 16-bit values with MFRAC fractional bits. Slopes and phases are signed 32-bit values. sat clamps to the signed 32-bit range, and >>> is an arithmetic shift of the full 48-bit product.
- R4: A beat is accepted only on a cycle where `in_valid` and `in_ready` are both high. On any other cycle the phases and the column position stay unchanged, whatever the data inputs carry.
- R5: `done` is high for exactly one cycle, the cycle after the last beat of the frame is accepted.
- R6: From that point `in_ready` stays low, and valid beats change no phase until the next clear.
- R7: A cycle with `clr` high zeroes every phase entry and restarts at column 0, group 0. `in_ready` is low during that cycle.
- R8: `rd_data` shows the phase at `rd_addr` one cycle after the address is applied. Any address at or beyond (n+1)^2 returns zero.
- R9: Lanes in the final group whose row index reaches (n+1)^2 or beyond are discarded and affect no readable entry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clr | input | 1 | Frame start: zero phases, restart counters |
| in_valid | input | 1 | Beat on the inputs is valid |
| in_ready | output | 1 | Block can accept a beat |
| in_wx | input | 16*LANES | X-half weights, one per lane |
| in_wy | input | 16*LANES | Y-half weights, one per lane |
| in_xs | input | 32 | X-slope of the current column |
| in_ys | input | 32 | Y-slope of the current column |
| done | output | 1 | One-cycle end-of-frame pulse |
| rd_addr | input | AW | Phase readout address |
| rd_data | output | 32 | Registered phase readout |

## Verification
The bench inserts idle cycles that carry garbage data. A design that ignored `in_valid` would fold that garbage into the phases or skip a column. It drives weights and slopes at the extremes of their ranges, in both signs, so a design that wrapped instead of clamping, or shifted logically, would read back values with flipped signs. It keeps pushing valid beats after `done`. A design that kept counting would corrupt a finished frame or pulse `done` twice. It also reads back every address, including those past the last row, and the entries next to the padded lanes, so a bank-select or padding error shows up as a wrong value.

// File: rtl/mvm_pkg.sv
package mvm_pkg;

    localparam int WEIGHT_W = 16;
    localparam int PHASE_W  = 32;
    localparam int PROD_W   = WEIGHT_W + PHASE_W;

    typedef logic signed [WEIGHT_W-1:0] weight_t;
    typedef logic signed [PHASE_W-1:0]  phase_t;

    typedef struct packed {
        weight_t wx;
        weight_t wy;
    } wpair_t;

    localparam logic signed [PROD_W-1:0] PMAX = PROD_W'(64'sd2147483647);
    localparam logic signed [PROD_W-1:0] PMIN = -PROD_W'(64'sd2147483648);

    // Scaled product, clamped to the phase range.
    function automatic phase_t scale_sat(weight_t w, phase_t s, int frac);
        logic signed [PROD_W-1:0] p;
        p = PROD_W'(w) * PROD_W'(s);
        p = p >>> frac;
        if (p > PMAX)      return phase_t'(PMAX);
        else if (p < PMIN) return phase_t'(PMIN);
        else               return phase_t'(p);
    endfunction

    // Three-operand sum, clamped to the phase range.
    function automatic phase_t add3_sat(phase_t a, phase_t b, phase_t c);
        logic signed [PHASE_W+1:0] s;
        s = (PHASE_W+2)'(a) + (PHASE_W+2)'(b) + (PHASE_W+2)'(c);
        if (s > (PHASE_W+2)'(PMAX))      return phase_t'(PMAX);
        else if (s < (PHASE_W+2)'(PMIN)) return phase_t'(PMIN);
        else                             return phase_t'(s);
    endfunction

endpackage

// File: rtl/mvm_phase_bank.sv
module mvm_phase_bank #(
    parameter int DEPTH = 7,
    parameter int IW    = 3
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   clr,
    input  logic                   wr_en,
    input  logic [IW-1:0]          wr_idx,
    input  mvm_pkg::phase_t        wr_data,
    input  logic [IW-1:0]          upd_idx,
    output mvm_pkg::phase_t        upd_val,
    input  logic [IW-1:0]          out_idx,
    output mvm_pkg::phase_t        out_val
);
    import mvm_pkg::*;

    phase_t mem [DEPTH];

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (wr_en) begin
            mem[wr_idx] <= wr_data;
        end
    end

    assign upd_val = (32'(upd_idx) < DEPTH) ? mem[upd_idx] : '0;
    assign out_val = (32'(out_idx) < DEPTH) ? mem[out_idx] : '0;

    // R7
    bank_cleared_chk: assert property (@(posedge clk) disable iff (rst)
        clr |=> (mem[0] == '0));

endmodule

// File: rtl/mvm_lane.sv
module mvm_lane #(
    parameter int MFRAC = 12
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            fire,
    input  mvm_pkg::wpair_t w,
    input  mvm_pkg::phase_t xs,
    input  mvm_pkg::phase_t ys,
    input  mvm_pkg::phase_t old_val,
    output mvm_pkg::phase_t new_val
);
    import mvm_pkg::*;

    phase_t px;
    phase_t py;

    assign px      = scale_sat(w.wx, xs, MFRAC);
    assign py      = scale_sat(w.wy, ys, MFRAC);
    assign new_val = add3_sat(old_val, px, py);

    // R3
    no_wrap_pos_chk: assert property (@(posedge clk) disable iff (rst)
        (fire && !old_val[31] && !px[31] && !py[31]) |-> !new_val[31]);

    // R3
    no_wrap_neg_chk: assert property (@(posedge clk) disable iff (rst)
        (fire && old_val[31] && px[31] && py[31]) |-> new_val[31]);

endmodule

// File: rtl/mvm_seq.sv
module mvm_seq #(
    parameter int GROUPS = 7,
    parameter int COLS   = 16,
    parameter int GW     = 3,
    parameter int CW     = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          in_valid,
    output logic          in_ready,
    output logic          fire,
    output logic [GW-1:0] grp,
    output logic          done
);
    logic [CW-1:0] col;
    logic          finished;
    logic          last_grp;
    logic          last_beat;

    assign in_ready  = !finished && !clr;
    assign fire      = in_valid && in_ready;
    assign last_grp  = (grp == GW'(GROUPS - 1));
    assign last_beat = last_grp && (col == CW'(COLS - 1));

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            grp      <= '0;
            col      <= '0;
            finished <= 1'b0;
            done     <= 1'b0;
        end else begin
            done <= 1'b0;
            if (fire) begin
                if (last_grp) begin
                    grp <= '0;
                    col <= last_beat ? col : col + 1'b1;
                end else begin
                    grp <= grp + 1'b1;
                end
                if (last_beat) begin
                    finished <= 1'b1;
                    done     <= 1'b1;
                end
            end
        end
    end

    // R5
    done_single_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R5
    done_follows_last_chk: assert property (@(posedge clk) disable iff (rst)
        (fire && last_beat && !clr) |=> done);

    // R6
    closed_after_done_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> !in_ready);

    // R4
    stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!fire && !clr) |=> ($stable(col) && $stable(grp)));

    // R2
    col_bound_chk: assert property (@(posedge clk) disable iff (rst)
        32'(col) < COLS);

endmodule

// File: rtl/split_mvm_mac.sv
module split_mvm_mac #(
    parameter int GRID_N = 4,
    parameter int LANES  = 4,
    parameter int MFRAC  = 12,
    parameter int NPH    = (GRID_N + 1) * (GRID_N + 1),
    parameter int AW     = $clog2(NPH + 1)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  clr,
    input  logic                  in_valid,
    output logic                  in_ready,
    input  logic [16*LANES-1:0]   in_wx,
    input  logic [16*LANES-1:0]   in_wy,
    input  logic [31:0]           in_xs,
    input  logic [31:0]           in_ys,
    output logic                  done,
    input  logic [AW-1:0]         rd_addr,
    output logic [31:0]           rd_data
);
    import mvm_pkg::*;

    localparam int COLS   = GRID_N * GRID_N;
    localparam int GROUPS = (NPH + LANES - 1) / LANES;
    localparam int GW     = (GROUPS > 1) ? $clog2(GROUPS) : 1;
    localparam int CW     = (COLS > 1) ? $clog2(COLS) : 1;
    localparam int LW     = (LANES > 1) ? $clog2(LANES) : 1;

    logic          fire;
    logic [GW-1:0] grp;
    phase_t        upd_val [LANES];
    phase_t        new_val [LANES];
    phase_t        out_val [LANES];
    logic [GW-1:0] out_idx;
    logic [LW-1:0] out_bank;
    phase_t        rd_mux;

    mvm_seq #(
        .GROUPS(GROUPS), .COLS(COLS), .GW(GW), .CW(CW)
    ) u_seq (
        .clk(clk), .rst(rst), .clr(clr), .in_valid(in_valid),
        .in_ready(in_ready), .fire(fire), .grp(grp), .done(done)
    );

    assign out_idx  = GW'(32'(rd_addr) / LANES);
    assign out_bank = LW'(32'(rd_addr) % LANES);

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        wpair_t wp;
        logic   keep;

        assign wp.wx = in_wx[16*l +: 16];
        assign wp.wy = in_wy[16*l +: 16];
        // rows past the end of the phase vector are dropped
        assign keep  = (32'(grp) * LANES + l) < NPH;

        mvm_lane #(.MFRAC(MFRAC)) u_lane (
            .clk(clk), .rst(rst), .fire(fire), .w(wp),
            .xs(phase_t'(in_xs)), .ys(phase_t'(in_ys)),
            .old_val(upd_val[l]), .new_val(new_val[l])
        );

        mvm_phase_bank #(.DEPTH(GROUPS), .IW(GW)) u_bank (
            .clk(clk), .rst(rst), .clr(clr),
            .wr_en(fire && keep), .wr_idx(grp), .wr_data(new_val[l]),
            .upd_idx(grp), .upd_val(upd_val[l]),
            .out_idx(out_idx), .out_val(out_val[l])
        );
    end

    always_comb begin
        rd_mux = '0;
        for (int l = 0; l < LANES; l++)
            if (out_bank == LW'(l)) rd_mux = out_val[l];
    end

    always_ff @(posedge clk) begin
        if (rst) rd_data <= '0;
        else     rd_data <= (32'(rd_addr) < NPH) ? rd_mux : '0;
    end

    // R8
    rd_range_chk: assert property (@(posedge clk) disable iff (rst)
        (32'(rd_addr) >= NPH) |=> (rd_data == '0));

endmodule

// File: tb/split_mvm_mac_tb.sv
module split_mvm_mac_tb;
    localparam int N     = 4;
    localparam int L     = 4;
    localparam int MFRAC = 12;
    localparam int NPH   = (N + 1) * (N + 1);
    localparam int AW    = $clog2(NPH + 1);
    localparam int COLS  = N * N;
    localparam int G     = (NPH + L - 1) / L;

    logic clk = 0, rst = 1, clr = 0, in_valid = 0;
    logic in_ready, done;
    logic [16*L-1:0] in_wx = '0, in_wy = '0;
    logic [31:0] in_xs = '0, in_ys = '0;
    logic [AW-1:0] rd_addr = '0;
    logic [31:0] rd_data;

    int checks = 0, fails = 0;
    int expv [NPH];

    always #10 clk = ~clk;

    split_mvm_mac #(.GRID_N(N), .LANES(L), .MFRAC(MFRAC)) u_dut (
        .clk(clk), .rst(rst), .clr(clr), .in_valid(in_valid),
        .in_ready(in_ready), .in_wx(in_wx), .in_wy(in_wy),
        .in_xs(in_xs), .in_ys(in_ys), .done(done),
        .rd_addr(rd_addr), .rd_data(rd_data)
    );

    function automatic int sat32(longint v);
        if (v > 64'sd2147483647)  return 32'h7fffffff;
        if (v < -64'sd2147483648) return 32'h80000000;
        return int'(v);
    endfunction

    function automatic int scl(shortint w, int s);
        longint p;
        p = longint'(w) * longint'(s);
        return sat32(p >>> MFRAC);
    endfunction

    task automatic chk(string req, longint act, longint expd);
        checks++;
        if (act != expd) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expd);
        end
    endtask

    function automatic int pick(int mode);
        case (mode)
            0: return int'($urandom % 20001) - 10000;
            1: return ($urandom % 2) ? 32'h7fffffff : 32'h80000000;
            default: return int'($urandom);
        endcase
    endfunction

    function automatic shortint pickw(int mode);
        case (mode)
            0: return shortint'(int'($urandom % 8193) - 4096);
            1: return ($urandom % 2) ? 16'sh7fff : 16'sh8000;
            default: return shortint'($urandom);
        endcase
    endfunction

    // Drive one column-group beat; the model updates on acceptance.
    task automatic beat(int g, int mode, int gaps);
        int xs, ys;
        shortint wx [L];
        shortint wy [L];
        xs = pick(mode);
        ys = pick(mode);
        for (int l = 0; l < L; l++) begin
            wx[l] = pickw(mode);
            wy[l] = pickw(mode);
        end
        if (gaps && ($urandom % 4 == 0)) begin
            // R4: idle cycle with garbage data, must be ignored
            @(negedge clk);
            in_valid = 0;
            in_wx = {$urandom, $urandom};
            in_wy = {$urandom, $urandom};
            in_xs = $urandom;
            in_ys = $urandom;
        end
        @(negedge clk);
        in_valid = 1;
        in_xs = xs;
        in_ys = ys;
        for (int l = 0; l < L; l++) begin
            in_wx[16*l +: 16] = wx[l];
            in_wy[16*l +: 16] = wy[l];
        end
        // R9: padded rows are skipped by the model
        for (int l = 0; l < L; l++) begin
            int row;
            row = g * L + l;
            if (row < NPH)
                expv[row] = sat32(longint'(expv[row]) + scl(wx[l], xs) + scl(wy[l], ys));
        end
    endtask

    task automatic run_frame(int mode, int gaps);
        for (int c = 0; c < COLS; c++) begin
            for (int g = 0; g < G; g++) begin
                beat(g, mode, gaps);
                if (c == 0 && g == 0) chk("R2 ready during frame", in_ready, 1);
                if (c == COLS - 1 && g == G - 1) chk("R5 done low before last", done, 0);
            end
        end
        @(negedge clk);
        in_valid = 0;
        chk("R5 done after last beat", done, 1);
        chk("R6 ready low after done", in_ready, 0);
        @(negedge clk);
        chk("R5 done one cycle", done, 0);
    endtask

    task automatic readout(string req);
        for (int a = 0; a < NPH; a++) begin
            rd_addr = AW'(a);
            @(negedge clk);
            chk(req, $signed(rd_data), expv[a]);
        end
        rd_addr = AW'(NPH);
        @(negedge clk);
        chk("R8 address past end", rd_data, 0);
    endtask

    task automatic do_clear();
        @(negedge clk);
        clr = 1;
        in_valid = 0;
        #1 chk("R7 ready low during clear", in_ready, 0);
        @(negedge clk);
        clr = 0;
        for (int i = 0; i < NPH; i++) expv[i] = 0;
    endtask

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < NPH; i++) expv[i] = 0;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        chk("R1 done low after reset", done, 0);
        chk("R1 ready high after reset", in_ready, 1);
        readout("R1 zero after reset");

        // Frame 1: moderate values with random stalls (R2, R3, R4)
        run_frame(0, 1);
        // R6: valid beats after done are ignored
        @(negedge clk);
        in_valid = 1;
        in_wx = {$urandom, $urandom};
        in_wy = {$urandom, $urandom};
        in_xs = 32'h7fffffff;
        in_ys = 32'h7fffffff;
        repeat (3) @(negedge clk);
        chk("R6 no second done", done, 0);
        in_valid = 0;
        readout("R3 phase value");

        // R7: clear then zero readback
        do_clear();
        readout("R7 zero after clear");

        // Frame 2: extreme values drive saturation (R3)
        run_frame(1, 0);
        readout("R3 saturated phase");

        // Frame 3: full-range random (R3, R9)
        do_clear();
        run_frame(2, 1);
        readout("R9 full range phase");

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule